// File: doc/BRIEF.md
# Flash Status Register Unit

This block holds the status byte of a parallel NOR flash controller and decides what a bus read returns. A command decoder upstream gives it decoded command codes. The program/erase engine gives it level flags for busy and for the two kinds of suspend, and one-cycle pulses for each error it detects. Three status bits follow the engine from cycle to cycle. Four error bits are sticky: once set, they stay set until a clear-status command arrives or the unit is reset.

The unit keeps track of the current read mode. It enters status-read mode when it sees a read-status command or the start of a program, erase or lock operation. It stays in that mode until a read-array command arrives. In status-read mode the output word carries the status byte in the low eight bits and zeros in the high eight. The byte is captured into an output latch only at specific bus events, and which events count depends on the bus read mode. In asynchronous mode the capture happens at the cycle in which chip enable and output enable first become active together. In burst mode the capture happens only when chip enable or address valid falls. Between capture events the same word is held on the output.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte is 0x80, the read mode is array, and `dq_out` equals `array_data`. The reset status value is visible in the first capture after reset.
- R2: Bit 7 of the status byte is the inverse of `eng_busy`, bit 6 equals `eng_erase_susp`, and bit 2 equals `eng_prog_susp`. Each takes the value its input had at the previous clock edge. Bit 0 is always 0.
- R3: Each sticky bit is set by a pulse and then stays set. `eng_erase_err` sets bit 5, `eng_prog_err` sets bit 4, `eng_vpp_err` sets bit 3 and `eng_lock_err` sets bit 1.
- R4: Command code 0x50 clears bits 5, 4, 3 and 1 at the next edge. It does not depend on any engine flag and does not change the read mode.
- R5: An `eng_seq_err` pulse sets bits 5 and 4 together.
- R6: If a sticky-bit set pulse arrives in the same cycle as a clear command, the set wins and that bit is 1 afterwards.
- R7: Command code 0x70 selects status-read mode.
- R8: Program (0x40 or 0x10), erase (0x20) and lock setup (0x60) also select status-read mode. Read array (0xFF) selects array mode. Any other code, including 0x50, leaves the mode unchanged.
- R9: In status-read mode `dq_out` is {8'h00, latched status byte}. In array mode it is `array_data`.
- R10: When `burst_mode` is 0, the latch takes the status byte held before an edge at the edge where `ce_n` and `oe_n` are first both low. At every other edge it holds its value.
- R11: When `burst_mode` is 1, the latch takes the status byte only at an edge where `ce_n` or `adv_n` has fallen since the previous edge. Otherwise the same word repeats on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 8 | Command code |
| eng_busy | input | 1 | Engine operation in progress |
| eng_erase_susp | input | 1 | Erase is suspended |
| eng_prog_susp | input | 1 | Program is suspended |
| eng_erase_err | input | 1 | Erase failure pulse |
| eng_prog_err | input | 1 | Program failure pulse |
| eng_vpp_err | input | 1 | Supply-too-low pulse |
| eng_lock_err | input | 1 | Operation hit a locked block pulse |
| eng_seq_err | input | 1 | Command sequence error pulse |
| burst_mode | input | 1 | 1 selects burst bus reads, 0 selects asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| array_data | input | 16 | Word read from the array |
| dq_out | output | 16 | Read data |

## Verification
A sticky-bit set pulse and a clear-status command can land in the same cycle. So can a bus capture event and a change of the status byte. The bench forces both cases directly: it issues 0x50 while driving an error pulse, and it lowers `ce_n` in the cycle an error pulse arrives. It then checks that the set wins and that the latch takes the byte from before the edge. Constrained random runs also mix commands, pulses and bus toggles freely, and every output word is compared with a cycle model built from the requirements.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    localparam int STAT_W = 8;
    localparam int CMD_W  = 8;

    localparam logic [STAT_W-1:0] STAT_RESET  = 8'h80;
    localparam logic [STAT_W-1:0] STICKY_MASK = 8'b0011_1010;

    localparam logic [CMD_W-1:0] OP_READ_STAT = 8'h70;
    localparam logic [CMD_W-1:0] OP_CLR_STAT  = 8'h50;
    localparam logic [CMD_W-1:0] OP_PROG_A    = 8'h40;
    localparam logic [CMD_W-1:0] OP_PROG_B    = 8'h10;
    localparam logic [CMD_W-1:0] OP_ERASE     = 8'h20;
    localparam logic [CMD_W-1:0] OP_LOCK      = 8'h60;
    localparam logic [CMD_W-1:0] OP_READ_ARR  = 8'hFF;

    typedef enum logic {
        MODE_ARRAY  = 1'b0,
        MODE_STATUS = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic busy;
        logic erase_susp;
        logic prog_susp;
        logic erase_err;
        logic prog_err;
        logic vpp_err;
        logic lock_err;
        logic seq_err;
    } eng_flags_t;

endpackage

// File: rtl/fsu_status_bits.sv
module fsu_status_bits
    import fsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_hit,
    input  eng_flags_t        flags,
    output logic [STAT_W-1:0] stat_q
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;
    logic [STAT_W-1:0] kept;
    logic [STAT_W-1:0] sets;

    always_comb begin
        kept = clr_hit ? '0 : (st_q.stat & STICKY_MASK);
        sets = '0;
        sets[5] = flags.erase_err | flags.seq_err;
        sets[4] = flags.prog_err  | flags.seq_err;
        sets[3] = flags.vpp_err;
        sets[1] = flags.lock_err;
        st_d.stat    = kept | sets;
        st_d.stat[7] = ~flags.busy;
        st_d.stat[6] = flags.erase_susp;
        st_d.stat[2] = flags.prog_susp;
        st_d.stat[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.stat <= STAT_RESET;
        else        st_q      <= st_d;
    end

    assign stat_q = st_q.stat;

    AST_READY_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_q[7] == !$past(flags.busy)); // R2
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((stat_q & $past(stat_q) & STICKY_MASK) == ($past(stat_q) & STICKY_MASK))); // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !flags.erase_err && !flags.prog_err && !flags.vpp_err
         && !flags.lock_err && !flags.seq_err) |=> ((stat_q & STICKY_MASK) == '0)); // R4
    AST_SEQ_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        flags.seq_err |=> (stat_q[5] && stat_q[4])); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && flags.vpp_err) |=> stat_q[3]); // R6

endmodule

// File: rtl/fsu_read_mode.sv
module fsu_read_mode
    import fsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output rd_mode_e         mode_q,
    output logic             clr_hit
);

    typedef struct packed {
        rd_mode_e mode;
    } md_t;

    md_t md_d, md_q;

    always_comb begin
        md_d    = md_q;
        clr_hit = cmd_valid && (cmd_code == OP_CLR_STAT);
        if (cmd_valid) begin
            unique case (cmd_code)
                OP_READ_STAT, OP_PROG_A, OP_PROG_B,
                OP_ERASE, OP_LOCK:  md_d.mode = MODE_STATUS;
                OP_READ_ARR:        md_d.mode = MODE_ARRAY;
                default:            md_d.mode = md_q.mode;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) md_q.mode <= MODE_ARRAY;
        else        md_q      <= md_d;
    end

    assign mode_q = md_q.mode;

    AST_READ_STAT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_READ_STAT) |=> mode_q == MODE_STATUS); // R7
    AST_ARRAY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_READ_ARR) |=> mode_q == MODE_ARRAY); // R8
    AST_CLEAR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_CLR_STAT) |=> $stable(mode_q)); // R4

endmodule

// File: rtl/fsu_bus_latch.sv
module fsu_bus_latch
    import fsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] snap_q
);

    typedef struct packed {
        logic              rd_prev;
        logic              ce_prev;
        logic              adv_prev;
        logic [STAT_W-1:0] snap;
    } lt_t;

    lt_t  lt_d, lt_q;
    logic rd_act;
    logic take;

    always_comb begin
        rd_act = !ce_n && !oe_n;
        if (burst_mode)
            take = (lt_q.ce_prev && !ce_n) || (lt_q.adv_prev && !adv_n);
        else
            take = rd_act && !lt_q.rd_prev;
        lt_d          = lt_q;
        lt_d.rd_prev  = rd_act;
        lt_d.ce_prev  = ce_n;
        lt_d.adv_prev = adv_n;
        if (take) lt_d.snap = stat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lt_q.rd_prev  <= 1'b0;
            lt_q.ce_prev  <= 1'b1;
            lt_q.adv_prev <= 1'b1;
            lt_q.snap     <= STAT_RESET;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign snap_q = lt_q.snap;

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && !(lt_q.ce_prev && !ce_n) && !(lt_q.adv_prev && !adv_n))
        |=> $stable(snap_q)); // R11
    AST_ASYNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_mode && !ce_n && !oe_n && !lt_q.rd_prev) |=> snap_q == $past(stat_q)); // R10

endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import fsu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              eng_busy,
    input  logic              eng_erase_susp,
    input  logic              eng_prog_susp,
    input  logic              eng_erase_err,
    input  logic              eng_prog_err,
    input  logic              eng_vpp_err,
    input  logic              eng_lock_err,
    input  logic              eng_seq_err,
    input  logic              burst_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out
);

    localparam int PAD_W = DATA_W - STAT_W;

    eng_flags_t        flags;
    rd_mode_e          mode_q;
    logic              clr_hit;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] snap_q;

    always_comb begin
        flags.busy       = eng_busy;
        flags.erase_susp = eng_erase_susp;
        flags.prog_susp  = eng_prog_susp;
        flags.erase_err  = eng_erase_err;
        flags.prog_err   = eng_prog_err;
        flags.vpp_err    = eng_vpp_err;
        flags.lock_err   = eng_lock_err;
        flags.seq_err    = eng_seq_err;
    end

    fsu_read_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .mode_q    (mode_q),
        .clr_hit   (clr_hit)
    );

    fsu_status_bits u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_hit (clr_hit),
        .flags   (flags),
        .stat_q  (stat_q)
    );

    fsu_bus_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_mode (burst_mode),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .adv_n      (adv_n),
        .stat_q     (stat_q),
        .snap_q     (snap_q)
    );

    always_comb begin
        if (mode_q == MODE_STATUS) dq_out = {{PAD_W{1'b0}}, snap_q};
        else                       dq_out = array_data;
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STATUS) |-> dq_out[DATA_W-1:STAT_W] == '0); // R9
    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ARRAY) |-> dq_out == array_data); // R9

endmodule

// File: tb/test_flash_status_unit.sv
`timescale 1ns/1ps
module test_flash_status_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic        eng_busy, eng_erase_susp, eng_prog_susp;
    logic        eng_erase_err, eng_prog_err, eng_vpp_err, eng_lock_err, eng_seq_err;
    logic        burst_mode, ce_n, oe_n, adv_n;
    logic [15:0] array_data;
    logic [15:0] dq_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] m_stat, m_snap;
    logic       m_status_mode;
    logic       m_rd_prev, m_ce_prev, m_adv_prev;

    always #5 clk = ~clk;

    flash_status_unit i_flash_status_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .eng_busy(eng_busy), .eng_erase_susp(eng_erase_susp), .eng_prog_susp(eng_prog_susp),
        .eng_erase_err(eng_erase_err), .eng_prog_err(eng_prog_err), .eng_vpp_err(eng_vpp_err),
        .eng_lock_err(eng_lock_err), .eng_seq_err(eng_seq_err), .burst_mode(burst_mode),
        .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n), .array_data(array_data), .dq_out(dq_out)
    );

    function automatic logic [7:0] next_stat();
        logic [7:0] s;
        s = (cmd_valid && cmd_code == 8'h50) ? 8'h00 : (m_stat & 8'h3A);
        if (eng_erase_err || eng_seq_err) s[5] = 1'b1;
        if (eng_prog_err  || eng_seq_err) s[4] = 1'b1;
        if (eng_vpp_err)  s[3] = 1'b1;
        if (eng_lock_err) s[1] = 1'b1;
        s[7] = !eng_busy;
        s[6] = eng_erase_susp;
        s[2] = eng_prog_susp;
        s[0] = 1'b0;
        return s;
    endfunction

    function automatic logic next_mode();
        if (!cmd_valid) return m_status_mode;
        case (cmd_code)
            8'h70, 8'h40, 8'h10, 8'h20, 8'h60: return 1'b1;
            8'hFF:                             return 1'b0;
            default:                           return m_status_mode;
        endcase
    endfunction

    function automatic logic take_now();
        if (burst_mode) return (m_ce_prev && !ce_n) || (m_adv_prev && !adv_n);
        return (!ce_n && !oe_n) && !m_rd_prev;
    endfunction

    function automatic logic [15:0] exp_dq();
        return m_status_mode ? {8'h00, m_snap} : array_data;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dq_out=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid = 0; cmd_code = 8'h00;
        eng_busy = 0; eng_erase_susp = 0; eng_prog_susp = 0;
        eng_erase_err = 0; eng_prog_err = 0; eng_vpp_err = 0; eng_lock_err = 0; eng_seq_err = 0;
        ce_n = 1; oe_n = 1; adv_n = 1;
    endtask

    // apply current inputs for one edge, update model, compare
    task automatic step(input string tag);
        logic [7:0] ns;
        logic       nm, tk;
        ns = next_stat();
        nm = next_mode();
        tk = take_now();
        @(posedge clk);
        #2;
        if (tk) m_snap = m_stat;
        m_stat        = ns;
        m_status_mode = nm;
        m_rd_prev     = !ce_n && !oe_n;
        m_ce_prev     = ce_n;
        m_adv_prev    = adv_n;
        check(tag, dq_out, exp_dq());
    endtask

    task automatic cmd_step(input logic [7:0] code, input string tag);
        cmd_valid = 1; cmd_code = code;
        step(tag);
        cmd_valid = 0;
    endtask

    // open a fresh async read so the latch takes the status held before the edge
    task automatic async_read(input string tag);
        ce_n = 1; oe_n = 1; step(tag);
        ce_n = 0; oe_n = 0; step(tag);
    endtask

    function automatic string rand_tag();
        if (!m_status_mode) return "R8";
        return burst_mode ? "R11" : "R10";
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] codes [8];
        void'($urandom(32'd2024));
        codes = '{8'h70, 8'h50, 8'h40, 8'h10, 8'h20, 8'h60, 8'hFF, 8'h33};
        idle_inputs();
        burst_mode = 0; array_data = 16'hA5C3; rst_n = 0;
        m_stat = 8'h80; m_snap = 8'h80; m_status_mode = 0;
        m_rd_prev = 0; m_ce_prev = 1; m_adv_prev = 1;
        repeat (3) @(posedge clk);
        #2; rst_n = 1;

        // R1: array mode after reset, first capture shows 0x80
        check("R1", dq_out, 16'hA5C3);
        cmd_step(8'h70, "R7");
        async_read("R1");
        check("R1", dq_out, 16'h0080);

        // R2: ready/suspend bits follow the engine
        eng_busy = 1; eng_erase_susp = 1; step("R2");
        async_read("R2");
        check("R2", dq_out, 16'h0040);
        eng_busy = 0; eng_erase_susp = 0; eng_prog_susp = 1; step("R2");
        async_read("R2");
        check("R2", dq_out, 16'h0084);
        eng_prog_susp = 0;

        // R3: sticky bits persist
        eng_vpp_err = 1; eng_lock_err = 1; step("R3");
        eng_vpp_err = 0; eng_lock_err = 0;
        repeat (3) step("R3");
        async_read("R3");
        check("R3", dq_out, 16'h008A);

        // R4: clear removes sticky bits, mode stays status
        cmd_step(8'h50, "R4");
        async_read("R4");
        check("R4", dq_out, 16'h0080);

        // R5: sequence error sets both error bits
        eng_seq_err = 1; step("R5"); eng_seq_err = 0;
        async_read("R5");
        check("R5", dq_out, 16'h00B0);

        // R6: set in same cycle as clear wins
        cmd_valid = 1; cmd_code = 8'h50; eng_prog_err = 1; step("R6");
        cmd_valid = 0; eng_prog_err = 0;
        async_read("R6");
        check("R6", dq_out, 16'h0090);
        cmd_step(8'h50, "R4");

        // R10: capture coincident with a pulse takes the pre-edge byte
        ce_n = 1; oe_n = 1; step("R10");
        ce_n = 0; oe_n = 0; eng_erase_err = 1; step("R10");
        eng_erase_err = 0;
        check("R10", dq_out, 16'h0080);
        step("R10");
        check("R10", dq_out, 16'h0080);

        // R11: burst mode holds until ce_n/adv_n falls
        burst_mode = 1; oe_n = 1; step("R11"); oe_n = 0; step("R11");
        check("R11", dq_out, 16'h0080);
        adv_n = 0; step("R11"); adv_n = 1;
        check("R11", dq_out, 16'h00A0);

        // R8: read array, unknown code, then erase command
        cmd_step(8'hFF, "R8");
        check("R8", dq_out, 16'hA5C3);
        cmd_step(8'h33, "R8");
        check("R8", dq_out, 16'hA5C3);
        cmd_step(8'h20, "R8");
        check("R9", dq_out, {8'h00, m_snap});
        cmd_step(8'h50, "R4");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            cmd_valid      = ($urandom % 5) == 0;
            cmd_code       = codes[$urandom % 8];
            eng_busy       = $urandom % 2;
            eng_erase_susp = ($urandom % 4) == 0;
            eng_prog_susp  = ($urandom % 4) == 0;
            eng_erase_err  = ($urandom % 16) == 0;
            eng_prog_err   = ($urandom % 16) == 0;
            eng_vpp_err    = ($urandom % 16) == 0;
            eng_lock_err   = ($urandom % 16) == 0;
            eng_seq_err    = ($urandom % 24) == 0;
            if (($urandom % 64) == 0) burst_mode = ~burst_mode;
            ce_n           = $urandom % 2;
            oe_n           = $urandom % 2;
            adv_n          = $urandom % 2;
            array_data     = 16'($urandom);
            step(rand_tag());
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule